// File: doc/BRIEF.md
# Repeater Channel Configuration Selector

This block works out the settings that each lane of a four-lane signal repeater actually uses. There are four settings per lane: a 9-bit equalizer boost word, a lane enable, a 2-bit output swing code and a 2-bit de-emphasis code. Each setting comes either from strap pins on the package or from configuration register bytes. The register file itself sits outside the block, and its bytes arrive here as plain inputs. A strap-mode pin chooses the source for swing, de-emphasis and out-of-band disable. A register override bit and the strap pin together choose the source for enable and boost.

The block also drives three status bytes that show the resolved settings of one lane. A two-bit pointer in the select register picks that lane. Each lane has an optional auto-enable input. When it is set, the lane runs only while its signal-detect flag is high. Every output is registered, so a change on any input shows at the outputs one clock later.

Top module: `rpt_cfg_select`

## Requirements
- R1: In strap mode the 3-bit boost strap code maps to the boost word as follows: 000→0x000, 001→0x001, 010→0x003, 011→0x007, 100→0x00F, 101→0x01F, 110→0x02F, 111→0x03F. The same word goes to every lane.
- R2: When `pin_mode` is 1, enable comes from `en_pins[c]` and boost comes from the strap code. The override bit `reg_select[0]` then has no effect.
- R3: When `pin_mode` is 0 and `reg_select[0]` is 0, enable and boost still come from the pins.
- R4: When `pin_mode` is 0 and `reg_select[0]` is 1, lane c takes its enable from `reg_ch_ctl[c][4]`. Its boost is {`reg_ch_ctl[c][0]`, `reg_ch_bst[c][7:0]`}.
- R5: The swing code is the same on all lanes. It comes from `swing_pins` in strap mode and from `reg_drive[3:2]` otherwise. The codes 00, 01, 10 and 11 mean 0.6, 0.8, 1.0 and 1.2 Vp-p.
- R6: The de-emphasis code comes from `deemph_pins` on all lanes in strap mode. Otherwise lane c reads `reg_deemph[2c+1:2c]`. The codes 00, 01, 10 and 11 mean 0, -3, -6 and -9 dB.
- R7: The out-of-band disable flag comes from `oob_dis_pin` in strap mode and from `reg_oob[0]` otherwise.
- R8: When `auto_en[c]` is 1, the effective enable of lane c is its selected enable ANDed with `sig_det[c]`. When `auto_en[c]` is 0, `sig_det[c]` has no effect.
- R9: `reg_select[5:4]` picks the reported lane. The status bytes are laid out as follows:
  - `stat_ctl`: bit 6 holds the out-of-band disable flag, bit 4 the enable and bit 0 boost bit 8. All other bits are 0.
  - `stat_boost`: boost bits 7:0.
  - `stat_drive`: bits 5:4 hold the swing code and bits 1:0 the de-emphasis code. All other bits are 0.
- R10: While `rst_n` is low, the outputs hold these values: every enable 1, every boost 0, every swing 10, every de-emphasis 00, `stat_ctl`=0x10, `stat_boost`=0x00 and `stat_drive`=0x20.
- R11: An input change reaches the outputs at the first rising clock edge after it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_mode | input | 1 | 1 = settings taken from strap pins |
| bst_pins | input | 3 | Boost strap code shared by all lanes |
| en_pins | input | 4 | Per-lane strap enable |
| swing_pins | input | 2 | Digitised swing strap code (GND=00, resistor=01, open=10, VDD=11) |
| deemph_pins | input | 2 | Digitised de-emphasis strap code, same encoding as the swing code |
| oob_dis_pin | input | 1 | Out-of-band disable strap |
| auto_en | input | 4 | Per-lane gate of enable by signal detect |
| sig_det | input | 4 | Per-lane signal-detect flag |
| reg_select | input | 8 | Select byte: bit 0 = register override, bits 5:4 = reported lane |
| reg_drive | input | 8 | Drive byte: bits 3:2 = swing code |
| reg_deemph | input | 8 | Packed de-emphasis codes, 2 bits per lane |
| reg_oob | input | 8 | Bit 0 = out-of-band disable |
| reg_ch_ctl | input | 4x8 | Per-lane control byte: bit 4 = enable, bit 0 = boost bit 8 |
| reg_ch_bst | input | 4x8 | Per-lane boost bits 7:0 |
| eff_en | output | 4 | Effective per-lane enable |
| eff_boost | output | 4x9 | Effective per-lane boost word |
| eff_swing | output | 4x2 | Effective per-lane swing code |
| eff_deemph | output | 4x2 | Effective per-lane de-emphasis code |
| stat_ctl | output | 8 | Status: out-of-band disable, enable, boost bit 8 |
| stat_boost | output | 8 | Status: boost bits 7:0 |
| stat_drive | output | 8 | Status: swing and de-emphasis codes |

## Verification
The assertions check several invariants on every cycle:
- In strap mode, all lanes carry one boost word and the swing strap code.
- The enable follows the pins or the control bytes, depending on the mode.
- A lane with auto-enable set and no signal detect is never enabled.
- The boost status byte mirrors the low boost bits of the lane chosen one cycle earlier.
- The reserved status bits stay 0.

Other behaviour is shown only by the bench's scenarios. This covers the exact strap-code-to-word table, the bit positions of the per-lane register fields and the packed de-emphasis byte, the status layout for each lane, the reset values and the one-cycle latency.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    localparam int NUM_LANES = 4;
    localparam int BOOST_W   = 9;
    localparam int CODE_W    = 2;
    localparam int STRAP_W   = 3;
    localparam logic [CODE_W-1:0] SWING_RST = 2'b10;
endpackage

// File: rtl/rcs_boost_expand.sv
module rcs_boost_expand #(
    parameter int BW = rcs_pkg::BOOST_W,
    parameter int SW = rcs_pkg::STRAP_W
) (
    input  logic [SW-1:0] code,
    output logic [BW-1:0] word
);
    // Codes 0..5 fill a ladder of ones; 6 drops bit 4 from the 6-bit ladder
    always_comb begin
        if (code == SW'(6))
            word = BW'(9'h02F);
        else if (code == SW'(7))
            word = BW'(9'h03F);
        else
            word = BW'((32'd1 << code) - 32'd1);
    end
endmodule

// File: rtl/rcs_lane_resolve.sv
module rcs_lane_resolve #(
    parameter int BW = rcs_pkg::BOOST_W
) (
    input  logic          use_regs,
    input  logic          pin_en,
    input  logic [BW-1:0] pin_word,
    input  logic [7:0]    ctl_byte,
    input  logic [7:0]    bst_byte,
    input  logic          auto_en,
    input  logic          sig_det,
    output logic          en,
    output logic [BW-1:0] boost
);
    logic en_src;

    always_comb begin
        en_src = use_regs ? ctl_byte[4] : pin_en;
        boost  = use_regs ? BW'({ctl_byte[0], bst_byte}) : pin_word;
        en     = en_src & (~auto_en | sig_det);
    end
endmodule

// File: rtl/rcs_status_mux.sv
module rcs_status_mux #(
    parameter int NCH = rcs_pkg::NUM_LANES,
    parameter int BW  = rcs_pkg::BOOST_W,
    parameter int CW  = rcs_pkg::CODE_W
) (
    input  logic [1:0]                 sel,
    input  logic                       oob_dis,
    input  logic [NCH-1:0]             en,
    input  logic [NCH-1:0][BW-1:0]     boost,
    input  logic [NCH-1:0][CW-1:0]     swing,
    input  logic [NCH-1:0][CW-1:0]     deemph,
    output logic [7:0]                 st_ctl,
    output logic [7:0]                 st_boost,
    output logic [7:0]                 st_drive
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [IW-1:0] idx;

    always_comb begin
        idx      = (int'(sel) < NCH) ? IW'(sel) : '0;
        st_ctl   = {1'b0, oob_dis, 1'b0, en[idx], 3'b000, boost[idx][8]};
        st_boost = boost[idx][7:0];
        st_drive = {2'b00, swing[idx], 2'b00, deemph[idx]};
    end
endmodule

// File: rtl/rpt_cfg_select.sv
module rpt_cfg_select #(
    parameter int NCH = rcs_pkg::NUM_LANES,
    parameter int BW  = rcs_pkg::BOOST_W,
    parameter int CW  = rcs_pkg::CODE_W,
    parameter int SW  = rcs_pkg::STRAP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pin_mode,
    input  logic [SW-1:0]           bst_pins,
    input  logic [NCH-1:0]          en_pins,
    input  logic [CW-1:0]           swing_pins,
    input  logic [CW-1:0]           deemph_pins,
    input  logic                    oob_dis_pin,
    input  logic [NCH-1:0]          auto_en,
    input  logic [NCH-1:0]          sig_det,
    input  logic [7:0]              reg_select,
    input  logic [7:0]              reg_drive,
    input  logic [7:0]              reg_deemph,
    input  logic [7:0]              reg_oob,
    input  logic [NCH-1:0][7:0]     reg_ch_ctl,
    input  logic [NCH-1:0][7:0]     reg_ch_bst,
    output logic [NCH-1:0]          eff_en,
    output logic [NCH-1:0][BW-1:0]  eff_boost,
    output logic [NCH-1:0][CW-1:0]  eff_swing,
    output logic [NCH-1:0][CW-1:0]  eff_deemph,
    output logic [7:0]              stat_ctl,
    output logic [7:0]              stat_boost,
    output logic [7:0]              stat_drive
);
    typedef struct packed {
        logic [NCH-1:0]         en;
        logic [NCH-1:0][BW-1:0] boost;
        logic [NCH-1:0][CW-1:0] swing;
        logic [NCH-1:0][CW-1:0] deemph;
        logic [7:0]             st_ctl;
        logic [7:0]             st_boost;
        logic [7:0]             st_drive;
    } cfg_state_t;

    cfg_state_t state_d, state_q;

    logic                   use_regs;
    logic                   oob_d;
    logic [BW-1:0]          strap_word;
    logic [NCH-1:0]         en_d;
    logic [NCH-1:0][BW-1:0] boost_d;
    logic [NCH-1:0][CW-1:0] swing_d;
    logic [NCH-1:0][CW-1:0] deemph_d;
    logic [7:0]             st_ctl_d, st_boost_d, st_drive_d;

    assign use_regs = ~pin_mode & reg_select[0];
    assign oob_d    = pin_mode ? oob_dis_pin : reg_oob[0];

    rcs_boost_expand #(.BW(BW), .SW(SW)) u_expand (
        .code (bst_pins),
        .word (strap_word)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        rcs_lane_resolve #(.BW(BW)) u_lane (
            .use_regs (use_regs),
            .pin_en   (en_pins[c]),
            .pin_word (strap_word),
            .ctl_byte (reg_ch_ctl[c]),
            .bst_byte (reg_ch_bst[c]),
            .auto_en  (auto_en[c]),
            .sig_det  (sig_det[c]),
            .en       (en_d[c]),
            .boost    (boost_d[c])
        );
        assign swing_d[c]  = pin_mode ? swing_pins  : reg_drive[3:2];
        assign deemph_d[c] = pin_mode ? deemph_pins : reg_deemph[CW*c +: CW];
    end

    rcs_status_mux #(.NCH(NCH), .BW(BW), .CW(CW)) u_status (
        .sel      (reg_select[5:4]),
        .oob_dis  (oob_d),
        .en       (en_d),
        .boost    (boost_d),
        .swing    (swing_d),
        .deemph   (deemph_d),
        .st_ctl   (st_ctl_d),
        .st_boost (st_boost_d),
        .st_drive (st_drive_d)
    );

    always_comb begin
        state_d          = state_q;
        state_d.en       = en_d;
        state_d.boost    = boost_d;
        state_d.swing    = swing_d;
        state_d.deemph   = deemph_d;
        state_d.st_ctl   = st_ctl_d;
        state_d.st_boost = st_boost_d;
        state_d.st_drive = st_drive_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.en       <= '1;
            state_q.boost    <= '0;
            for (int c = 0; c < NCH; c++) state_q.swing[c] <= rcs_pkg::SWING_RST;
            state_q.deemph   <= '0;
            state_q.st_ctl   <= 8'h10;
            state_q.st_boost <= 8'h00;
            state_q.st_drive <= {2'b00, rcs_pkg::SWING_RST, 4'b0000};
        end else begin
            state_q <= state_d;
        end
    end

    assign eff_en     = state_q.en;
    assign eff_boost  = state_q.boost;
    assign eff_swing  = state_q.swing;
    assign eff_deemph = state_q.deemph;
    assign stat_ctl   = state_q.st_ctl;
    assign stat_boost = state_q.st_boost;
    assign stat_drive = state_q.st_drive;
endmodule

// File: rtl/rpt_cfg_select_chk.sv
module rpt_cfg_select_chk #(
    parameter int NCH = rcs_pkg::NUM_LANES,
    parameter int BW  = rcs_pkg::BOOST_W,
    parameter int CW  = rcs_pkg::CODE_W,
    parameter int SW  = rcs_pkg::STRAP_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    pin_mode,
    input logic [SW-1:0]           bst_pins,
    input logic [NCH-1:0]          en_pins,
    input logic [CW-1:0]           swing_pins,
    input logic [CW-1:0]           deemph_pins,
    input logic                    oob_dis_pin,
    input logic [NCH-1:0]          auto_en,
    input logic [NCH-1:0]          sig_det,
    input logic [7:0]              reg_select,
    input logic [7:0]              reg_drive,
    input logic [7:0]              reg_deemph,
    input logic [7:0]              reg_oob,
    input logic [NCH-1:0][7:0]     reg_ch_ctl,
    input logic [NCH-1:0][7:0]     reg_ch_bst,
    input logic [NCH-1:0]          eff_en,
    input logic [NCH-1:0][BW-1:0]  eff_boost,
    input logic [NCH-1:0][CW-1:0]  eff_swing,
    input logic [NCH-1:0][CW-1:0]  eff_deemph,
    input logic [7:0]              stat_ctl,
    input logic [7:0]              stat_boost,
    input logic [7:0]              stat_drive
);
    logic [1:0]     sel_q;
    logic [CW-1:0]  swing_pins_q;
    logic [NCH-1:0] ctl_en;
    logic           boost_same;
    logic           swing_pin_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q        <= '0;
            swing_pins_q <= '0;
        end else begin
            sel_q        <= reg_select[5:4];
            swing_pins_q <= swing_pins;
        end
    end

    always_comb begin
        boost_same   = 1'b1;
        swing_pin_ok = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            ctl_en[c] = reg_ch_ctl[c][4];
            if (eff_boost[c] != eff_boost[0]) boost_same = 1'b0;
            if (eff_swing[c] != swing_pins_q) swing_pin_ok = 1'b0;
        end
    end

    // R2
    strap_boost_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mode |=> boost_same);

    // R2
    strap_en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_mode && auto_en == '0) |=> eff_en == $past(en_pins));

    // R4
    reg_en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_mode && reg_select[0] && auto_en == '0) |=> eff_en == $past(ctl_en));

    // R5
    strap_swing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mode |=> swing_pin_ok);

    // R8
    auto_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(auto_en & ~sig_det)) |=> (eff_en & $past(auto_en & ~sig_det)) == '0);

    // R9
    stat_boost_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(reg_select[5:4]) < NCH) |=> stat_boost == eff_boost[sel_q][7:0]);

    // R9
    stat_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |-> ((stat_ctl & 8'hAE) == 8'h00 && (stat_drive & 8'hCC) == 8'h00));
endmodule

bind rpt_cfg_select rpt_cfg_select_chk #(.NCH(NCH), .BW(BW), .CW(CW), .SW(SW)) u_chk (.*);

// File: tb/rpt_cfg_select_tb.sv
module rpt_cfg_select_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_mode = 1'b1;
    logic [2:0] bst_pins = 3'b000;
    logic [3:0] en_pins = 4'b1111;
    logic [1:0] swing_pins = 2'b11;
    logic [1:0] deemph_pins = 2'b10;
    logic oob_dis_pin = 1'b0;
    logic [3:0] auto_en = 4'b0000;
    logic [3:0] sig_det = 4'b0000;
    logic [7:0] reg_select = 8'h00;
    logic [7:0] reg_drive = 8'h04;
    logic [7:0] reg_deemph = 8'hE4;
    logic [7:0] reg_oob = 8'h01;
    logic [3:0][7:0] reg_ch_ctl = {8'h11, 8'h01, 8'h10, 8'h11};
    logic [3:0][7:0] reg_ch_bst = {8'h3F, 8'hFF, 8'hAA, 8'h55};
    logic [3:0] eff_en;
    logic [3:0][8:0] eff_boost;
    logic [3:0][1:0] eff_swing;
    logic [3:0][1:0] eff_deemph;
    logic [7:0] stat_ctl, stat_boost, stat_drive;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rpt_cfg_select u_dut (
        .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .bst_pins(bst_pins),
        .en_pins(en_pins), .swing_pins(swing_pins), .deemph_pins(deemph_pins),
        .oob_dis_pin(oob_dis_pin), .auto_en(auto_en), .sig_det(sig_det),
        .reg_select(reg_select), .reg_drive(reg_drive), .reg_deemph(reg_deemph),
        .reg_oob(reg_oob), .reg_ch_ctl(reg_ch_ctl), .reg_ch_bst(reg_ch_bst),
        .eff_en(eff_en), .eff_boost(eff_boost), .eff_swing(eff_swing),
        .eff_deemph(eff_deemph), .stat_ctl(stat_ctl), .stat_boost(stat_boost),
        .stat_drive(stat_drive)
    );

    typedef struct packed {
        logic       pm;
        logic [2:0] bst;
        logic [3:0] enp;
        logic       ovr;
        logic [1:0] sel;
        logic [3:0] en;
        logic [8:0] boost;
        logic [7:0] s1;
        logic [7:0] s2;
        logic [7:0] s3;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'b000, 4'b1111, 1'b0, 2'd0, 4'b1111, 9'h000, 8'h10, 8'h00, 8'h32},
        '{1'b1, 3'b110, 4'b0101, 1'b1, 2'd1, 4'b0101, 9'h02F, 8'h00, 8'h2F, 8'h32},
        '{1'b1, 3'b111, 4'b1000, 1'b0, 2'd3, 4'b1000, 9'h03F, 8'h10, 8'h3F, 8'h32},
        '{1'b0, 3'b011, 4'b0011, 1'b0, 2'd2, 4'b0011, 9'h007, 8'h40, 8'h07, 8'h12},
        '{1'b0, 3'b011, 4'b0011, 1'b1, 2'd2, 4'b1011, 9'h1FF, 8'h41, 8'hFF, 8'h12},
        '{1'b0, 3'b000, 4'b0000, 1'b1, 2'd0, 4'b1011, 9'h155, 8'h51, 8'h55, 8'h10},
        '{1'b0, 3'b000, 4'b0000, 1'b1, 2'd3, 4'b1011, 9'h13F, 8'h51, 8'h3F, 8'h13},
        '{1'b0, 3'b000, 4'b0000, 1'b1, 2'd1, 4'b1011, 9'h0AA, 8'h50, 8'hAA, 8'h11},
        '{1'b1, 3'b001, 4'b0010, 1'b0, 2'd1, 4'b0010, 9'h001, 8'h10, 8'h01, 8'h32},
        '{1'b1, 3'b010, 4'b1111, 1'b0, 2'd2, 4'b1111, 9'h003, 8'h10, 8'h03, 8'h32},
        '{1'b1, 3'b100, 4'b1111, 1'b0, 2'd0, 4'b1111, 9'h00F, 8'h10, 8'h0F, 8'h32},
        '{1'b1, 3'b101, 4'b1111, 1'b0, 2'd3, 4'b1111, 9'h01F, 8'h10, 8'h1F, 8'h32}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reset_defaults(input string req);
        for (int c = 0; c < 4; c++) begin
            chk(req, 32'(eff_boost[c]), 32'h0);
            chk(req, 32'(eff_swing[c]), 32'h2);
            chk(req, 32'(eff_deemph[c]), 32'h0);
        end
        chk(req, 32'(eff_en), 32'hF);
        chk(req, 32'(stat_ctl), 32'h10);
        chk(req, 32'(stat_boost), 32'h00);
        chk(req, 32'(stat_drive), 32'h20);
    endtask

    initial begin
        // R10: reset values while inputs point elsewhere
        bst_pins = 3'b111; en_pins = 4'b0000;
        #12;
        reset_defaults("R10 in reset");
        @(negedge clk); rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            string rq;
            @(negedge clk);
            pin_mode   = VECS[v].pm;
            bst_pins   = VECS[v].bst;
            en_pins    = VECS[v].enp;
            reg_select = {2'b00, VECS[v].sel, 3'b000, VECS[v].ovr};
            @(negedge clk);
            rq = VECS[v].pm ? "R1 R2" : (VECS[v].ovr ? "R4" : "R3");
            chk(rq, 32'(eff_en), 32'(VECS[v].en));
            chk(rq, 32'(eff_boost[VECS[v].sel]), 32'(VECS[v].boost));
            if (VECS[v].pm)
                for (int c = 0; c < 4; c++) chk("R1 all lanes", 32'(eff_boost[c]), 32'(VECS[v].boost));
            chk("R9 ctl", 32'(stat_ctl), 32'(VECS[v].s1));
            chk("R9 boost", 32'(stat_boost), 32'(VECS[v].s2));
            chk("R9 drive", 32'(stat_drive), 32'(VECS[v].s3));
            chk("R5", 32'(eff_swing[0]), 32'(VECS[v].s3[5:4]));
            chk("R6", 32'(eff_deemph[VECS[v].sel]), 32'(VECS[v].s3[1:0]));
            chk("R7", 32'(stat_ctl[6]), 32'(VECS[v].s1[6]));
        end

        // R6: full packing of the de-emphasis byte, R5 swing from register on all lanes
        @(negedge clk);
        pin_mode = 1'b0; reg_select = 8'h01;
        @(negedge clk);
        chk("R6 packed", 32'(eff_deemph), 32'hE4);
        chk("R5 reg all", 32'(eff_swing), 32'h55);

        // R8: auto-enable gating in strap mode
        @(negedge clk);
        pin_mode = 1'b1; reg_select = 8'h00; en_pins = 4'b1111;
        auto_en = 4'b0101; sig_det = 4'b0001;
        @(negedge clk);
        chk("R8 gated", 32'(eff_en), 32'hB);
        sig_det = 4'b0101;
        @(negedge clk);
        chk("R8 detected", 32'(eff_en), 32'hF);
        auto_en = 4'b0000; sig_det = 4'b0000;
        @(negedge clk);
        chk("R8 ignored", 32'(eff_en), 32'hF);
        pin_mode = 1'b0; reg_select = 8'h01; auto_en = 4'b1111;
        @(negedge clk);
        chk("R8 reg mode", 32'(eff_en), 32'h0);

        // R11: one-cycle latency
        auto_en = 4'b0000; pin_mode = 1'b1; reg_select = 8'h00; bst_pins = 3'b000;
        @(negedge clk);
        bst_pins = 3'b111;
        @(posedge clk); #1;
        chk("R11 after edge", 32'(eff_boost[0]), 32'h03F);
        @(negedge clk);
        bst_pins = 3'b001;
        #1;
        chk("R11 before edge", 32'(eff_boost[0]), 32'h03F);
        @(posedge clk); #1;
        chk("R11 next edge", 32'(eff_boost[0]), 32'h001);

        // R10: asynchronous reset mid-run
        @(negedge clk);
        pin_mode = 1'b0; reg_select = 8'h31;
        @(negedge clk);
        #1 rst_n = 1'b0;
        #1;
        reset_defaults("R10 mid-run");
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule